// File: doc/BRIEF.md
# Host Port Word Access Sequencer

This block turns single 32-bit word reads and writes, addressed by full 32-bit DSP byte addresses, into the series of 16-bit host port cycles that the port needs. It sits above a halfword cycle engine. That engine owns the strobe timing and the ready wait for each 16-bit transfer, and it may report a timeout. The sequencer only decides which register each cycle goes to, which halfword each cycle carries, and in what order the cycles run.

The first access after reset starts by writing the port's control register. The control value is a parameter whose bit 0 set means "low halfword first". The control register is not written again until a reconfigure pulse arrives. Every access writes the 32-bit address register next, then moves the two data halfwords through the data register without auto-increment.

A read returns the two halfwords joined into one word. Any timeout reported by the engine ends the access at once. The block then answers with an error and is ready for the next request.

Top module: `hostport_word_seq`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `eng_valid` is 0 and `rsp_valid` is 0. Reset re-arms the control write, so the next access starts with it again, even if a control write was already done.
- R2: The first access after reset begins with two control-register cycles (`eng_sel` = 00, `eng_write` = 1). The first cycle has `eng_hsel` = 0 and carries `CTRL_VAL[15:0]`. The second has `eng_hsel` = 1 and carries `CTRL_VAL[31:16]`.
- R3: Later accesses do not write the control register. A one-cycle `reconfig` pulse makes the next access write it again.
- R4: Each access writes the address register (`eng_sel` = 10, `eng_write` = 1) in two cycles: first `req_addr[15:0]` with `eng_hsel` = 0, then `req_addr[31:16]` with `eng_hsel` = 1. Both cycles come before any data cycle.
- R5: A write moves its data through the data register (`eng_sel` = 11, `eng_write` = 1) in two cycles: `req_wdata[15:0]` with `eng_hsel` = 0, then `req_wdata[31:16]` with `eng_hsel` = 1. The response has `rsp_err` = 0 and `rsp_rdata` = 0.
- R6: A read uses two data-register cycles (`eng_sel` = 11, `eng_write` = 0), first with `eng_hsel` = 0 and then with `eng_hsel` = 1. It returns `rsp_rdata` = {second halfword, first halfword} with `rsp_err` = 0.
- R7: Each halfword is a separate engine cycle. `eng_sel`, `eng_hsel`, `eng_write` and `eng_wdata` do not change while `eng_valid` is 1, until `eng_done` arrives. The total is exactly 4 cycles, or 6 cycles when the control write is included.
- R8: If `eng_done` comes with `eng_timeout` = 1, no further engine cycle is issued. On the next cycle `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0.
- R9: If a timeout hits either control cycle, the control write stays pending. The next access starts with the control write again.
- R10: `req_ready` is 0 from acceptance until the response. `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reconfig | input | 1 | Pulse: rewrite control register on next access |
| req_valid | input | 1 | Word request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 32 | DSP byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access aborted by engine timeout |
| rsp_rdata | output | 32 | Read word |
| eng_valid | output | 1 | Halfword cycle requested |
| eng_sel | output | 2 | Register select: 00 control, 10 address, 11 data |
| eng_hsel | output | 1 | 0 first halfword, 1 second halfword |
| eng_write | output | 1 | Halfword direction, 1 = write |
| eng_wdata | output | 16 | Halfword to write |
| eng_done | input | 1 | Engine finished the current halfword |
| eng_timeout | input | 1 | With eng_done: the halfword timed out |
| eng_rdata | input | 16 | Halfword read, valid with eng_done |

## Verification
The assertions assume that the engine raises `eng_done` only while `eng_valid` is 1, for one cycle per halfword, and that `eng_timeout` counts only when it comes with `eng_done`. The bench's engine model answers each halfword after a fixed wait and drops `eng_done` after one cycle. It injects a timeout at one chosen step of an access, so these conditions always hold. Requests and reconfigure pulses are driven only while the sequencer is idle.

// File: rtl/hostport_word_seq.sv
module hostport_word_seq #(
  parameter logic [31:0] CTRL_VAL = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reconfig,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        eng_valid,
  output logic [1:0]  eng_sel,
  output logic        eng_hsel,
  output logic        eng_write,
  output logic [15:0] eng_wdata,
  input  logic        eng_done,
  input  logic        eng_timeout,
  input  logic [15:0] eng_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_C0, S_C1, S_A0, S_A1, S_D0, S_D1} st_t;
  st_t st;
  logic cfg_pend, wr_q;
  logic [31:0] addr_q, wd_q;

  assign req_ready = (st == S_IDLE);
  assign eng_valid = (st != S_IDLE);
  assign eng_hsel  = (st == S_C1) || (st == S_A1) || (st == S_D1);
  assign eng_sel   = (st == S_C0 || st == S_C1) ? 2'b00 :
                     (st == S_A0 || st == S_A1) ? 2'b10 : 2'b11;
  assign eng_write = (st == S_D0 || st == S_D1) ? wr_q : 1'b1;

  always_comb begin
    case (st)
      S_C0:    eng_wdata = CTRL_VAL[15:0];
      S_C1:    eng_wdata = CTRL_VAL[31:16];
      S_A0:    eng_wdata = addr_q[15:0];
      S_A1:    eng_wdata = addr_q[31:16];
      S_D0:    eng_wdata = wd_q[15:0];
      S_D1:    eng_wdata = wd_q[31:16];
      default: eng_wdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cfg_pend  <= 1'b1;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (reconfig) cfg_pend <= 1'b1;
      if (st == S_IDLE) begin
        if (req_valid) begin
          wr_q      <= req_write;
          addr_q    <= req_addr;
          wd_q      <= req_wdata;
          rsp_err   <= 1'b0;
          rsp_rdata <= '0;
          st        <= cfg_pend ? S_C0 : S_A0;
        end
      end else if (eng_done) begin
        if (eng_timeout) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= '0;
        end else begin
          case (st)
            S_C0: st <= S_C1;
            S_C1: begin
              st <= S_A0;
              if (!reconfig) cfg_pend <= 1'b0;
            end
            S_A0: st <= S_A1;
            S_A1: st <= S_D0;
            S_D0: begin
              if (!wr_q) rsp_rdata[15:0] <= eng_rdata;
              st <= S_D1;
            end
            S_D1: begin
              if (!wr_q) rsp_rdata[31:16] <= eng_rdata;
              st        <= S_IDLE;
              rsp_valid <= 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_done |=> eng_valid && $stable(eng_sel) && $stable(eng_hsel)
                               && $stable(eng_write) && $stable(eng_wdata));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_done && eng_timeout |=> rsp_valid && rsp_err && !eng_valid);

  assert_addr_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_done && !eng_timeout && eng_sel == 2'b10 && eng_hsel
      |=> eng_valid && eng_sel == 2'b11 && !eng_hsel);

  assert_first_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> eng_valid && !eng_hsel
                               && (eng_sel == 2'b00 || eng_sel == 2'b10));
endmodule

// File: tb/hostport_word_seq_test.sv
module hostport_word_seq_test;
  localparam int PERIOD = 10;
  localparam logic [31:0] CTRL = 32'h0000_0001;

  typedef struct packed {
    logic        rcfg;
    logic        wr;
    logic [2:0]  to;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd0, 32'h9000_0000, 32'h00F0_00F0, 32'h0},
    '{1'b0, 1'b1, 3'd0, 32'h9000_1554, 32'h00AA_00AA, 32'h0},
    '{1'b0, 1'b0, 3'd0, 32'h9000_0038, 32'h0,         32'h1234_ABCD},
    '{1'b0, 1'b0, 3'd2, 32'h9000_0AA8, 32'h0,         32'h5555_AAAA},
    '{1'b1, 1'b1, 3'd0, 32'h0001_0000, 32'hDEAD_BEEF, 32'h0},
    '{1'b1, 1'b0, 3'd1, 32'h0001_0004, 32'h0,         32'h0F0F_F0F0},
    '{1'b0, 1'b0, 3'd0, 32'h0001_0000, 32'h0,         32'hCAFE_F00D},
    '{1'b0, 1'b1, 3'd4, 32'h0180_0004, 32'hF61F_3823, 32'h0},
    '{1'b0, 1'b0, 3'd4, 32'h0180_0000, 32'h0,         32'h3779_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, reconfig = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, eng_valid, eng_hsel, eng_write;
  logic [31:0] rsp_rdata;
  logic [1:0] eng_sel;
  logic [15:0] eng_wdata;
  logic eng_done, eng_timeout;
  logic [15:0] eng_rdata;

  int nchk = 0, nfail = 0;
  int to_step = 0;
  logic [31:0] rd_word = '0;
  bit pend = 1'b1;

  logic [19:0] lg [8];
  int nsteps, cnt;

  always #(PERIOD/2) clk = ~clk;

  hostport_word_seq #(.CTRL_VAL(CTRL)) uut (
    .clk(clk), .rst_n(rst_n), .reconfig(reconfig),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .eng_valid(eng_valid), .eng_sel(eng_sel), .eng_hsel(eng_hsel),
    .eng_write(eng_write), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_timeout(eng_timeout), .eng_rdata(eng_rdata));

  // engine model: answers each halfword after a fixed wait, logs it
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_done <= 1'b0; eng_timeout <= 1'b0; eng_rdata <= '0;
      cnt <= 0; nsteps <= 0;
    end else begin
      if (req_valid && req_ready) nsteps <= 0;
      if (eng_done) begin
        eng_done <= 1'b0; eng_timeout <= 1'b0; cnt <= 0;
      end else if (eng_valid) begin
        if (cnt == 2) begin
          eng_done    <= 1'b1;
          eng_timeout <= (nsteps + 1 == to_step);
          eng_rdata   <= eng_hsel ? rd_word[31:16] : rd_word[15:0];
          if (nsteps < 8)
            lg[nsteps] <= {eng_sel, eng_hsel, eng_write, eng_write ? eng_wdata : 16'h0};
          nsteps <= nsteps + 1;
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string ctag);
    logic [19:0] ex [6];
    string tg [6];
    int k = 0, ne;
    bit had_ctrl = pend;
    if (pend) begin
      ex[k] = {2'b00, 1'b0, 1'b1, CTRL[15:0]};  tg[k] = ctag; k++;
      ex[k] = {2'b00, 1'b1, 1'b1, CTRL[31:16]}; tg[k] = ctag; k++;
    end
    ex[k] = {2'b10, 1'b0, 1'b1, v.addr[15:0]};  tg[k] = "R4"; k++;
    ex[k] = {2'b10, 1'b1, 1'b1, v.addr[31:16]}; tg[k] = "R4"; k++;
    ex[k] = {2'b11, 1'b0, v.wr, v.wr ? v.wd[15:0] : 16'h0};  tg[k] = v.wr ? "R5" : "R6"; k++;
    ex[k] = {2'b11, 1'b1, v.wr, v.wr ? v.wd[31:16] : 16'h0}; tg[k] = v.wr ? "R5" : "R6"; k++;
    ne = (v.to != 0) ? int'(v.to) : k;
    if (had_ctrl && (v.to == 0 || v.to > 2)) pend = 1'b0;

    to_step = int'(v.to);
    rd_word = v.rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", 64'(req_ready), 64'd0);
    begin
      int w = 0;
      while (!rsp_valid && w < 200) begin @(negedge clk); w++; end
      chk(rsp_valid == 1'b1, "R10", 64'(rsp_valid), 64'd1);
    end
    chk(nsteps == ne, (v.to != 0) ? "R8" : "R7", 64'(nsteps), 64'(ne));
    for (int i = 0; i < ne && i < nsteps; i++)
      chk(lg[i] == ex[i], tg[i], 64'(lg[i]), 64'(ex[i]));
    chk(rsp_err == (v.to != 0), (v.to != 0) ? "R8" : "R6", 64'(rsp_err), 64'(v.to != 0));
    chk(rsp_rdata == ((v.to != 0 || v.wr) ? 32'h0 : v.rd), v.wr ? "R5" : "R6",
        64'(rsp_rdata), 64'((v.to != 0 || v.wr) ? 32'h0 : v.rd));
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !eng_valid && !rsp_valid, "R1",
        64'({req_ready, eng_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !eng_valid && !rsp_valid, "R1",
        64'({req_ready, eng_valid, rsp_valid}), 64'b100);

    for (int n = 0; n < NV; n++) begin
      if (VEC[n].rcfg) begin
        @(negedge clk); reconfig = 1'b1;
        @(negedge clk); reconfig = 1'b0;
        pend = 1'b1;   // R3: reconfigure re-arms the control write
      end
      // control steps: R2 after reset, R3 after reconfig, R9 after a control timeout
      run_vec(VEC[n], (n == 0) ? "R2" : (VEC[n].rcfg ? "R3" : "R9"));
    end

    // R1: reset in the middle of an access aborts it and re-arms the control write
    to_step = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h9000_0100; req_wdata = 32'h1111_2222;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !eng_valid && !rsp_valid, "R1",
        64'({req_ready, eng_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    pend = 1'b1;
    run_vec('{1'b0, 1'b1, 3'd0, 32'h9000_0200, 32'h3333_4444, 32'h0}, "R1");
    run_vec('{1'b0, 1'b0, 3'd0, 32'h9000_0200, 32'h0, 32'h8000_0001}, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule